// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home cluster of a 16-cluster shared-memory machine and owns the coherence directory for the memory blocks homed there. Each directory entry records which clusters hold a copy of the block and whether the single holder has modified it. Coherence requests arrive one per cycle. Each carries an opcode, the cluster that sent it, a block index and, for owner-originated messages, a second cluster number. For every accepted request the controller reads the entry, decides the outcome, rewrites the entry and emits at most one message on each of its two outbound ports.

Requests that go to other clusters (forwarded reads, forwarded read-exclusives and invalidations) leave on the request port. Answers to the requester (shared data, exclusive data and negative acknowledgements) leave on the reply port. The two ports are physically separate, so a reply is never queued behind a request. A read or read-exclusive that meets a modified block is forwarded straight to the owner instead of being recalled through the home. The owner later reports back with a sharing write-back or an ownership-transfer message. An invalidation is a single multicast message whose destination is a cluster mask. The exclusive data reply tells the requester how many acknowledgements to wait for.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is uncached: no presence bit set and the modified flag clear. While no request is presented, neither port is valid.
- R2: An entry whose modified flag is set always has exactly one presence bit set, and that bit names the owner.
- R3: A read (req_op 0) to an entry that is not modified gives a reply of kind 0 (shared data) to req_src and adds req_src to the presence vector.
- R4: A read to a modified entry from a cluster other than the owner sends a request of kind 0 (forwarded read) whose rq_dest mask is the owner's bit alone and whose rq_origin is req_src. There is no reply and the entry is unchanged.
- R5: A sharing write-back (req_op 3) from the owner, with req_aux naming the reader, leaves the entry unmodified with exactly the owner and the reader as sharers.
- R6: A read-exclusive (req_op 1) to an entry that is not modified sends a request of kind 2 (invalidate) to a mask holding every sharer except req_src. No invalidate is sent when that mask is empty. The entry becomes modified with req_src as the only holder.
- R7: A read-exclusive to a modified entry from a non-owner sends a request of kind 1 (forwarded read-exclusive) to the owner with rq_origin = req_src, and leaves the entry unchanged. A later ownership transfer (req_op 4) from the owner makes req_aux the only holder, still modified.
- R8: A write-back (req_op 2) from the owner returns the entry to uncached and sends nothing.
- R9: The exclusive data reply (reply kind 1, sent to req_src) carries in rp_inv_cnt the number of clusters in the invalidate mask sent in the same cycle, or 0 when none is sent.
- R10: A request that the entry state makes illegal (write-back, sharing write-back or ownership transfer from a non-owner, or a read or read-exclusive from the current owner) gets a reply of kind 2 (NAK) to req_src, and the entry is not changed.
- R11: req_ready is low exactly when a port that the request needs is not ready. A request presented while req_ready is low sends nothing and leaves the entry unchanged. A request that needs both ports sends on both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Inbound request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 3 | 0 read, 1 read-exclusive, 2 write-back, 3 sharing write-back, 4 ownership transfer |
| req_src | input | 4 | Sending cluster |
| req_aux | input | 4 | Reader (op 3) or new owner (op 4) |
| req_blk | input | 5 | Block index |
| rq_valid | output | 1 | Outbound request message valid |
| rq_ready | input | 1 | Request network can take a message |
| rq_kind | output | 2 | 0 forwarded read, 1 forwarded read-exclusive, 2 invalidate |
| rq_dest | output | 16 | Destination cluster mask |
| rq_origin | output | 4 | Cluster that started the transaction |
| rq_blk | output | 5 | Block index |
| rp_valid | output | 1 | Outbound reply message valid |
| rp_ready | input | 1 | Reply network can take a message |
| rp_kind | output | 2 | 0 shared data, 1 exclusive data, 2 NAK |
| rp_dest | output | 4 | Destination cluster |
| rp_blk | output | 5 | Block index |
| rp_inv_cnt | output | 5 | Invalidations to be acknowledged |

## Verification
The assertions assume that req_src and req_aux are valid cluster numbers. They also assume that the owner-originated messages (ops 3 and 4) name a cluster that is not the owner in req_aux, and that the request fields stay still while req_valid is high and req_ready is low. The directed stimulus builds every entry state through legal sequences of reads, read-exclusives and owner reports, so these assumptions always hold. The only illegal traffic it sends is the deliberate NAK cases. Back-pressure is applied to one port at a time, and the held request is then re-presented unchanged.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_READX    = 3'd1,
    OP_WRBACK   = 3'd2,
    OP_SHARE_WB = 3'd3,
    OP_OWN_XFER = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RQ_FWD_READ  = 2'd0,
    RQ_FWD_READX = 2'd1,
    RQ_INVAL     = 2'd2
  } rq_e;

  typedef enum logic [1:0] {
    RP_DATA_SH = 2'd0,
    RP_DATA_EX = 2'd1,
    RP_NAK     = 2'd2
  } rp_e;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NCL  = 16,
  parameter int NBLK = 32,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BW-1:0]  rd_addr,
  output logic           rd_dirty,
  output logic [NCL-1:0] rd_pv,
  input  logic           wr_en,
  input  logic [BW-1:0]  wr_addr,
  input  logic           wr_dirty,
  input  logic [NCL-1:0] wr_pv
);
  logic           dirty_q [NBLK];
  logic [NCL-1:0] pv_q    [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty_q[g] <= 1'b0;
        pv_q[g]    <= '0;
      end else if (wr_en && wr_addr == BW'(g)) begin
        dirty_q[g] <= wr_dirty;
        pv_q[g]    <= wr_pv;
      end
    end
  end

  assign rd_dirty = dirty_q[rd_addr];
  assign rd_pv    = pv_q[rd_addr];

  // R2: a modified entry names exactly one holder, on read and on write
  p_dirty_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dirty |-> $onehot(rd_pv)) and (wr_en && wr_dirty |-> $onehot(wr_pv)));
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int NCL   = 16,
  localparam int CW   = $clog2(NCL),
  localparam int CNTW = $clog2(NCL + 1)
) (
  input  op_e              op,
  input  logic [CW-1:0]    src,
  input  logic [CW-1:0]    aux,
  input  logic             e_dirty,
  input  logic [NCL-1:0]   e_pv,
  output logic             need_rq,
  output rq_e              rq_kind,
  output logic [NCL-1:0]   rq_dest,
  output logic             need_rp,
  output rp_e              rp_kind,
  output logic [CNTW-1:0]  rp_cnt,
  output logic             upd,
  output logic             n_dirty,
  output logic [NCL-1:0]   n_pv
);
  function automatic logic [NCL-1:0] bit_of(input logic [CW-1:0] c);
    logic [NCL-1:0] m;
    m    = '0;
    m[c] = 1'b1;
    return m;
  endfunction

  function automatic logic [CW-1:0] first_set(input logic [NCL-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCL - 1; i >= 0; i--) if (v[i]) r = CW'(i);
    return r;
  endfunction

  function automatic logic [CNTW-1:0] pop(input logic [NCL-1:0] v);
    logic [CNTW-1:0] n;
    n = '0;
    for (int i = 0; i < NCL; i++) n = n + CNTW'(v[i]);
    return n;
  endfunction

  logic [NCL-1:0] sbit, others;
  logic [CW-1:0]  owner;
  logic           src_owns, nak;

  always_comb begin
    sbit     = bit_of(src);
    others   = e_pv & ~sbit;
    owner    = first_set(e_pv);
    src_owns = e_dirty && (owner == src);
    need_rq  = 1'b0;
    rq_kind  = RQ_FWD_READ;
    rq_dest  = '0;
    need_rp  = 1'b0;
    rp_kind  = RP_DATA_SH;
    rp_cnt   = '0;
    upd      = 1'b0;
    n_dirty  = e_dirty;
    n_pv     = e_pv;
    nak      = 1'b0;
    unique case (op)
      OP_READ: begin
        if (src_owns) nak = 1'b1;
        else if (e_dirty) begin
          need_rq = 1'b1;
          rq_kind = RQ_FWD_READ;
          rq_dest = bit_of(owner);
        end else begin
          need_rp = 1'b1;
          rp_kind = RP_DATA_SH;
          upd     = 1'b1;
          n_dirty = 1'b0;
          n_pv    = e_pv | sbit;
        end
      end
      OP_READX: begin
        if (src_owns) nak = 1'b1;
        else if (e_dirty) begin
          need_rq = 1'b1;
          rq_kind = RQ_FWD_READX;
          rq_dest = bit_of(owner);
        end else begin
          need_rp = 1'b1;
          rp_kind = RP_DATA_EX;
          rp_cnt  = pop(others);
          if (others != '0) begin
            need_rq = 1'b1;
            rq_kind = RQ_INVAL;
            rq_dest = others;
          end
          upd     = 1'b1;
          n_dirty = 1'b1;
          n_pv    = sbit;
        end
      end
      OP_WRBACK: begin
        if (src_owns) begin
          upd     = 1'b1;
          n_dirty = 1'b0;
          n_pv    = '0;
        end else nak = 1'b1;
      end
      OP_SHARE_WB: begin
        if (src_owns) begin
          upd     = 1'b1;
          n_dirty = 1'b0;
          n_pv    = sbit | bit_of(aux);
        end else nak = 1'b1;
      end
      OP_OWN_XFER: begin
        if (src_owns) begin
          upd     = 1'b1;
          n_dirty = 1'b1;
          n_pv    = bit_of(aux);
        end else nak = 1'b1;
      end
      default: nak = 1'b1;
    endcase
    if (nak) begin
      need_rp = 1'b1;
      rp_kind = RP_NAK;
    end
  end

  always_comb begin
    if (need_rq && rq_kind == RQ_INVAL)
      p_inv_skips_src_r6: assert (rq_dest[src] == 1'b0 && rq_dest != '0);
    if (need_rp && rp_kind == RP_DATA_EX)
      p_count_match_r9: assert (32'(rp_cnt) == (need_rq ? $countones(rq_dest) : 0));
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import dir_pkg::*;
#(
  parameter int NCL   = 16,
  parameter int NBLK  = 32,
  localparam int CW   = $clog2(NCL),
  localparam int BW   = $clog2(NBLK),
  localparam int CNTW = $clog2(NCL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [CW-1:0]   req_src,
  input  logic [CW-1:0]   req_aux,
  input  logic [BW-1:0]   req_blk,
  output logic            rq_valid,
  input  logic            rq_ready,
  output logic [1:0]      rq_kind,
  output logic [NCL-1:0]  rq_dest,
  output logic [CW-1:0]   rq_origin,
  output logic [BW-1:0]   rq_blk,
  output logic            rp_valid,
  input  logic            rp_ready,
  output logic [1:0]      rp_kind,
  output logic [CW-1:0]   rp_dest,
  output logic [BW-1:0]   rp_blk,
  output logic [CNTW-1:0] rp_inv_cnt
);
  logic           e_dirty, need_rq, need_rp, upd, n_dirty, fire, wr_en;
  logic [NCL-1:0] e_pv, n_pv, d_rq_dest;
  rq_e            d_rq_kind;
  rp_e            d_rp_kind;

  dir_store #(.NCL(NCL), .NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_blk), .rd_dirty(e_dirty), .rd_pv(e_pv),
    .wr_en(wr_en), .wr_addr(req_blk), .wr_dirty(n_dirty), .wr_pv(n_pv)
  );

  dir_decide #(.NCL(NCL)) u_decide (
    .op(op_e'(req_op)), .src(req_src), .aux(req_aux),
    .e_dirty(e_dirty), .e_pv(e_pv),
    .need_rq(need_rq), .rq_kind(d_rq_kind), .rq_dest(d_rq_dest),
    .need_rp(need_rp), .rp_kind(d_rp_kind), .rp_cnt(rp_inv_cnt),
    .upd(upd), .n_dirty(n_dirty), .n_pv(n_pv)
  );

  assign req_ready = (!need_rq || rq_ready) && (!need_rp || rp_ready);
  assign fire      = req_valid && req_ready;
  assign wr_en     = fire && upd;

  assign rq_valid  = fire && need_rq;
  assign rq_kind   = d_rq_kind;
  assign rq_dest   = d_rq_dest;
  assign rq_origin = req_src;
  assign rq_blk    = req_blk;

  assign rp_valid  = fire && need_rp;
  assign rp_kind   = d_rp_kind;
  assign rp_dest   = req_src;
  assign rp_blk    = req_blk;

  // R4: a forwarded request goes to exactly one cluster
  p_fwd_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind != 2'd2 |-> $onehot(rq_dest));
  // R10: a NAK never coincides with an entry update
  p_nak_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid && rp_kind == 2'd2 |-> !wr_en && !rq_valid);
  // R11: a stalled request is silent and changes nothing
  p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> !rq_valid && !rp_valid && !wr_en);
  // R1: idle means quiet ports
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !rq_valid && !rp_valid);
endmodule

// File: tb/tb_home_dir_ctrl.sv
module tb_home_dir_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_op = '0;
  logic [3:0]  req_src = '0, req_aux = '0;
  logic [4:0]  req_blk = '0;
  logic        rq_valid, rq_ready = 1'b1;
  logic [1:0]  rq_kind;
  logic [15:0] rq_dest;
  logic [3:0]  rq_origin;
  logic [4:0]  rq_blk;
  logic        rp_valid, rp_ready = 1'b1;
  logic [1:0]  rp_kind;
  logic [3:0]  rp_dest;
  logic [4:0]  rp_blk;
  logic [4:0]  rp_inv_cnt;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // captured outputs of the last request
  logic        c_rdy, c_rqv, c_rpv;
  logic [1:0]  c_rqk, c_rpk;
  logic [15:0] c_rqd;
  logic [3:0]  c_org, c_rpd;
  logic [4:0]  c_cnt;

  home_dir_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_src(req_src), .req_aux(req_aux), .req_blk(req_blk),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_kind(rq_kind),
    .rq_dest(rq_dest), .rq_origin(rq_origin), .rq_blk(rq_blk),
    .rp_valid(rp_valid), .rp_ready(rp_ready), .rp_kind(rp_kind),
    .rp_dest(rp_dest), .rp_blk(rp_blk), .rp_inv_cnt(rp_inv_cnt)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [3:0] src,
                      input logic [4:0] blk, input logic [3:0] aux);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src = src; req_blk = blk; req_aux = aux;
    #1;
    c_rdy = req_ready; c_rqv = rq_valid; c_rpv = rp_valid;
    c_rqk = rq_kind; c_rpk = rp_kind; c_rqd = rq_dest;
    c_org = rq_origin; c_rpd = rp_dest; c_cnt = rp_inv_cnt;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 idle rq_valid", 32'(rq_valid), 0);
    check("R1 idle rp_valid", 32'(rp_valid), 0);
    send(3'd1, 4'd3, 5'd0, 4'd0);
    check("R1 empty entry: no inval", 32'(c_rqv), 0);
    check("R9 count zero", 32'(c_cnt), 0);
    check("R9 exclusive data kind", 32'(c_rpk), 1);
  endtask

  task automatic t_reads();
    send(3'd0, 4'd2, 5'd1, 4'd0);
    check("R3 data reply valid", 32'(c_rpv), 1);
    check("R3 shared data kind", 32'(c_rpk), 0);
    check("R3 reply dest", 32'(c_rpd), 2);
    send(3'd0, 4'd5, 5'd1, 4'd0);
    check("R3 second reader", 32'(c_rpd), 5);
    send(3'd1, 4'd2, 5'd1, 4'd0);
    check("R6 inval sent", 32'(c_rqv), 1);
    check("R6 inval kind", 32'(c_rqk), 2);
    check("R6 inval mask excludes requester", 32'(c_rqd), 32'h0020);
    check("R9 count one", 32'(c_cnt), 1);
    check("R11 both ports same cycle", 32'(c_rpv), 1);
  endtask

  task automatic t_fwd_read();
    send(3'd0, 4'd7, 5'd1, 4'd0);
    check("R4 forwarded", 32'(c_rqv), 1);
    check("R4 fwd read kind", 32'(c_rqk), 0);
    check("R4 owner mask", 32'(c_rqd), 32'h0004);
    check("R4 origin", 32'(c_org), 7);
    check("R4 no reply", 32'(c_rpv), 0);
    send(3'd3, 4'd2, 5'd1, 4'd7);
    check("R5 sharing wb silent", 32'(c_rqv | c_rpv), 0);
    send(3'd1, 4'd9, 5'd1, 4'd0);
    check("R5 both sharers invalidated", 32'(c_rqd), 32'h0084);
    check("R9 count two", 32'(c_cnt), 2);
  endtask

  task automatic t_fwd_readx();
    send(3'd1, 4'd4, 5'd1, 4'd0);
    check("R7 fwd readx kind", 32'(c_rqk), 1);
    check("R7 owner mask", 32'(c_rqd), 32'h0200);
    check("R7 origin", 32'(c_org), 4);
    check("R7 no reply", 32'(c_rpv), 0);
    send(3'd4, 4'd9, 5'd1, 4'd4);
    send(3'd0, 4'd6, 5'd1, 4'd0);
    check("R7 new owner", 32'(c_rqd), 32'h0010);
    check("R2 single owner forward", 32'(c_rqv), 1);
  endtask

  task automatic t_wrback();
    send(3'd2, 4'd4, 5'd1, 4'd0);
    check("R8 wb silent", 32'(c_rqv | c_rpv), 0);
    send(3'd0, 4'd6, 5'd1, 4'd0);
    check("R8 read after wb gets data", 32'(c_rpk), 0);
    send(3'd1, 4'd6, 5'd1, 4'd0);
    check("R8 no other sharers", 32'(c_cnt), 0);
  endtask

  task automatic t_illegal();
    send(3'd2, 4'd3, 5'd1, 4'd0);
    check("R10 wb non-owner NAK", 32'(c_rpk), 2);
    check("R10 NAK dest", 32'(c_rpd), 3);
    send(3'd0, 4'd6, 5'd1, 4'd0);
    check("R10 owner read NAK", 32'(c_rpk), 2);
    check("R10 NAK no request", 32'(c_rqv), 0);
    send(3'd4, 4'd1, 5'd1, 4'd5);
    check("R10 xfer non-owner NAK", 32'(c_rpk), 2);
    send(3'd1, 4'd8, 5'd1, 4'd0);
    check("R10 entry unchanged", 32'(c_rqd), 32'h0040);
  endtask

  task automatic t_backpressure();
    rp_ready = 1'b0;
    send(3'd0, 4'd1, 5'd2, 4'd0);
    check("R11 ready low reply blocked", 32'(c_rdy), 0);
    check("R11 no reply when blocked", 32'(c_rpv), 0);
    rp_ready = 1'b1;
    send(3'd1, 4'd2, 5'd2, 4'd0);
    check("R11 blocked read left no bit", 32'(c_cnt), 0);
    check("R11 no inval", 32'(c_rqv), 0);
    rq_ready = 1'b0;
    send(3'd0, 4'd3, 5'd2, 4'd0);
    check("R11 ready low request blocked", 32'(c_rdy), 0);
    check("R11 no forward when blocked", 32'(c_rqv), 0);
    rq_ready = 1'b1;
    send(3'd0, 4'd3, 5'd2, 4'd0);
    check("R11 forward after release", 32'(c_rqd), 32'h0004);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_reads();
    t_fwd_read();
    t_fwd_readx();
    t_wrback();
    t_illegal();
    t_backpressure();
    finish_run();
  end

  initial begin
    #(PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule